// File: doc/BRIEF.md
# Coincident-Current Line Select Decoder

This block turns a 12-bit word address into the active-low select lines for a coincident-current magnetic core array of 64 X lines by 64 Y lines. Each axis has an A end and a B end. Each end has eight driver groups, so one A-end select paired with one B-end select picks one of the 64 lines on that axis. The block drives four groups of eight active-low selects (X-A, X-B, Y-A, Y-B) and four active-low drive enables (A-end source, A-end sink, B-end source, B-end sink).

The address is captured into a holding register by a one-cycle `load` pulse. The selects then stay fixed through the read phase and the write phase of a core cycle. The direction of the current comes from two active-low phase strobes:
- The read phase makes the A end source current and the B end sink it.
- The write phase reverses these roles while the same selects stay active.
- If both strobes are low at once, every drive enable is withheld.

A low `en` releases every select and every enable.

Top module: `core_line_select`

## Requirements
- R1: A synchronous reset empties the holding register and clears its loaded flag. Afterwards all 32 selects and all four drive enables read high.
- R2: The X A-end group `xa_sel_n` decodes address bits [2:0]. Exactly the line whose index equals that value is low.
- R3: The X B-end group `xb_sel_n` decodes address bits [5:3] the same way.
- R4: The Y A-end group `ya_sel_n` decodes bits [8:6], and the Y B-end group `yb_sel_n` decodes bits [11:9].
- R5: An address is taken into the holding register on a rising clock edge at which `load` is high, and the selects reflect it from that edge on. A change of `addr` without `load` leaves the selects unchanged.
- R6: While `en` is low, all 32 selects and all four drive enables are high, with no clock delay.
- R7: With `rd_n`=0 and `wr_n`=1 (read phase), `a_src_n` and `b_snk_n` are low and `a_snk_n` and `b_src_n` are high.
- R8: With `wr_n`=0 and `rd_n`=1 (write phase), `a_snk_n` and `b_src_n` are low and `a_src_n` and `b_snk_n` are high, while the selects keep their values.
- R9: With `rd_n` and `wr_n` both low, all four drive enables are high.
- R10: A `load` pulse that arrives while `rd_n` or `wr_n` is low is ignored, and the held address and the selects keep their values.
- R11: A held address whose low six bits are octal 50 drives X A-select 0 and X B-select 5 low.
- R12: Until the first accepted load after reset, the selects and the drive enables stay high even with `en` high and a phase strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables selects and drive enables, active high |
| load | input | 1 | Captures `addr` into the holding register |
| addr | input | 12 | Word address |
| rd_n | input | 1 | Read phase strobe, active low |
| wr_n | input | 1 | Write phase strobe, active low |
| xa_sel_n | output | 8 | X A-end group selects, active low |
| xb_sel_n | output | 8 | X B-end group selects, active low |
| ya_sel_n | output | 8 | Y A-end group selects, active low |
| yb_sel_n | output | 8 | Y B-end group selects, active low |
| a_src_n | output | 1 | A ends source current, active low |
| a_snk_n | output | 1 | A ends sink current, active low |
| b_src_n | output | 1 | B ends source current, active low |
| b_snk_n | output | 1 | B ends sink current, active low |

## Verification
The only internal state is the held address and its loaded flag. A wrong value in either shows at the ports on the first clock after the faulty load:
- a wrong held address puts the low select on the wrong line of some group;
- a loaded flag that is set early releases selects before any load;
- a flag that is never set keeps every line high.

Errors in the phase logic have no delay at all. They show as a wrong pair of drive enables, or as enables that stay asserted while both strobes are low, in the same cycle as the strobe change. The bench therefore checks selects one cycle after each load and checks the enables within the cycle of the strobe pattern under test.

// File: rtl/core_sel_pkg.sv
package core_sel_pkg;

    localparam int ADDR_W     = 12;
    localparam int FIELD_W    = 3;
    localparam int NUM_FIELDS = ADDR_W / FIELD_W;
    localparam int LINES      = 1 << FIELD_W;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [LINES-1:0]   group_n_t;

    // Field order inside the held address, least significant field first.
    typedef enum logic [1:0] {
        FLD_XA = 2'd0,
        FLD_XB = 2'd1,
        FLD_YA = 2'd2,
        FLD_YB = 2'd3
    } field_id_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_CLASH = 2'd3
    } phase_e;

    typedef struct packed {
        logic a_src_n;
        logic a_snk_n;
        logic b_src_n;
        logic b_snk_n;
    } drive_n_t;

    localparam drive_n_t DRIVE_OFF = '{a_src_n: 1'b1, a_snk_n: 1'b1,
                                       b_src_n: 1'b1, b_snk_n: 1'b1};

    function automatic phase_e classify_phase(input logic rd_n, input logic wr_n);
        phase_e p;
        case ({rd_n, wr_n})
            2'b01:   p = PH_READ;
            2'b10:   p = PH_WRITE;
            2'b00:   p = PH_CLASH;
            default: p = PH_IDLE;
        endcase
        return p;
    endfunction

    function automatic logic [FIELD_W-1:0] field_of(input logic [ADDR_W-1:0] a,
                                                    input field_id_e id);
        return a[int'(id)*FIELD_W +: FIELD_W];
    endfunction

endpackage

// File: rtl/cs_addr_hold.sv
module cs_addr_hold
    import core_sel_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          block,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] addr_q,
    output logic          held
);

    logic take;

    assign take = load && !block;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            held   <= 1'b0;
        end else if (take) begin
            addr_q <= addr;
            held   <= 1'b1;
        end
    end

endmodule

// File: rtl/cs_line_decoder.sv
module cs_line_decoder #(
    parameter int FW = 3,
    localparam int NL = 1 << FW
) (
    input  logic          ena,
    input  logic [FW-1:0] field,
    output logic [NL-1:0] sel_n
);

    for (genvar i = 0; i < NL; i++) begin : g_line
        assign sel_n[i] = !(ena && (field == FW'(i)));
    end

endmodule

// File: rtl/cs_phase_ctl.sv
module cs_phase_ctl
    import core_sel_pkg::*;
(
    input  logic     ok,
    input  logic     rd_n,
    input  logic     wr_n,
    output phase_e   phase,
    output drive_n_t drv
);

    always_comb begin
        phase = classify_phase(rd_n, wr_n);
        drv   = DRIVE_OFF;
        if (ok) begin
            case (phase)
                PH_READ: begin
                    drv.a_src_n = 1'b0;
                    drv.b_snk_n = 1'b0;
                end
                PH_WRITE: begin
                    drv.a_snk_n = 1'b0;
                    drv.b_src_n = 1'b0;
                end
                default: drv = DRIVE_OFF;
            endcase
        end
    end

endmodule

// File: rtl/core_line_select.sv
module core_line_select
    import core_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [LINES-1:0]  xa_sel_n,
    output logic [LINES-1:0]  xb_sel_n,
    output logic [LINES-1:0]  ya_sel_n,
    output logic [LINES-1:0]  yb_sel_n,
    output logic              a_src_n,
    output logic              a_snk_n,
    output logic              b_src_n,
    output logic              b_snk_n
);

    logic [ADDR_W-1:0] addr_q;
    logic              held;
    logic              live;
    logic              phase_busy;
    phase_e            phase;
    drive_n_t          drv;
    group_n_t          grp_n [NUM_FIELDS];

    assign phase_busy = !rd_n || !wr_n;
    assign live       = en && held;

    cs_addr_hold #(.AW(ADDR_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .block  (phase_busy),
        .addr   (addr),
        .addr_q (addr_q),
        .held   (held)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
        cs_line_decoder #(.FW(FIELD_W)) u_dec (
            .ena   (live),
            .field (field_of(addr_q, field_id_e'(g))),
            .sel_n (grp_n[g])
        );
    end

    assign xa_sel_n = grp_n[FLD_XA];
    assign xb_sel_n = grp_n[FLD_XB];
    assign ya_sel_n = grp_n[FLD_YA];
    assign yb_sel_n = grp_n[FLD_YB];

    cs_phase_ctl u_phase (
        .ok    (live),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .phase (phase),
        .drv   (drv)
    );

    assign a_src_n = drv.a_src_n;
    assign a_snk_n = drv.a_snk_n;
    assign b_src_n = drv.b_src_n;
    assign b_snk_n = drv.b_snk_n;

endmodule

// File: rtl/core_line_select_chk.sv
module core_line_select_chk
    import core_sel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              load,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_n,
    input logic              wr_n,
    input logic              held,
    input logic [ADDR_W-1:0] addr_q,
    input logic [LINES-1:0]  xa_sel_n,
    input logic [LINES-1:0]  xb_sel_n,
    input logic [LINES-1:0]  ya_sel_n,
    input logic [LINES-1:0]  yb_sel_n,
    input logic              a_src_n,
    input logic              a_snk_n,
    input logic              b_src_n,
    input logic              b_snk_n
);

    logic [4*LINES-1:0] all_sel_n;
    logic [3:0]         all_drv_n;

    assign all_sel_n = {xa_sel_n, xb_sel_n, ya_sel_n, yb_sel_n};
    assign all_drv_n = {a_src_n, a_snk_n, b_src_n, b_snk_n};

    assert_group_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~xa_sel_n) && $onehot0(~xb_sel_n));

    assert_group_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ya_sel_n) && $onehot0(~yb_sel_n));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (load && rd_n && wr_n) |=> (addr_q == $past(addr)) && held);

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !en |-> (&all_sel_n) && (&all_drv_n));

    assert_read_pair_R7: assert property (@(posedge clk) disable iff (rst)
        !a_src_n |-> !b_snk_n && a_snk_n && b_src_n && !rd_n);

    assert_write_pair_R8: assert property (@(posedge clk) disable iff (rst)
        !a_snk_n |-> !b_src_n && a_src_n && b_snk_n && !wr_n);

    assert_clash_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |-> (&all_drv_n));

    assert_load_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (load && (!rd_n || !wr_n)) |=> $stable(addr_q));

    assert_octal50_R11: assert property (@(posedge clk) disable iff (rst)
        (held && en && addr_q[5:0] == 6'o50) |-> (xa_sel_n == 8'hFE) && (xb_sel_n == 8'hDF));

    assert_unloaded_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !held |-> (&all_sel_n) && (&all_drv_n));

endmodule

bind core_line_select core_line_select_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .addr     (addr),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .held     (held),
    .addr_q   (addr_q),
    .xa_sel_n (xa_sel_n),
    .xb_sel_n (xb_sel_n),
    .ya_sel_n (ya_sel_n),
    .yb_sel_n (yb_sel_n),
    .a_src_n  (a_src_n),
    .a_snk_n  (a_snk_n),
    .b_src_n  (b_src_n),
    .b_snk_n  (b_snk_n)
);

// File: tb/tb_core_line_select.sv
module tb_core_line_select;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [11:0] addr = '0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  xa_sel_n, xb_sel_n, ya_sel_n, yb_sel_n;
    logic        a_src_n, a_snk_n, b_src_n, b_snk_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    core_line_select dut (
        .clk(clk), .rst(rst), .en(en), .load(load), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n),
        .xa_sel_n(xa_sel_n), .xb_sel_n(xb_sel_n),
        .ya_sel_n(ya_sel_n), .yb_sel_n(yb_sel_n),
        .a_src_n(a_src_n), .a_snk_n(a_snk_n),
        .b_src_n(b_src_n), .b_snk_n(b_snk_n)
    );

    // {address, xa index, xb index, ya index, yb index}
    localparam logic [23:0] VEC [8] = '{
        {12'o0050, 3'd0, 3'd5, 3'd0, 3'd0},
        {12'o7777, 3'd7, 3'd7, 3'd7, 3'd7},
        {12'o0000, 3'd0, 3'd0, 3'd0, 3'd0},
        {12'o1234, 3'd4, 3'd3, 3'd2, 3'd1},
        {12'o4321, 3'd1, 3'd2, 3'd3, 3'd4},
        {12'o0707, 3'd7, 3'd0, 3'd7, 3'd0},
        {12'o7070, 3'd0, 3'd7, 3'd0, 3'd7},
        {12'o5555, 3'd5, 3'd5, 3'd5, 3'd5}
    };

    function automatic logic [7:0] low_at(input logic [2:0] idx);
        return ~(8'b1 << idx);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [11:0] a);
        @(negedge clk);
        addr = a;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    function automatic logic [31:0] sels();
        return {xa_sel_n, xb_sel_n, ya_sel_n, yb_sel_n};
    endfunction

    function automatic logic [3:0] drvs();
        return {a_src_n, a_snk_n, b_src_n, b_snk_n};
    endfunction

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        @(negedge clk);
        chk("R1 selects after reset", sels(), 32'hFFFF_FFFF);
        chk("R1 drives after reset", {28'd0, drvs()}, 32'hF);
        rd_n = 1'b0;
        #1;
        chk("R12 no drive before load", {28'd0, drvs()}, 32'hF);
        chk("R12 no select before load", sels(), 32'hFFFF_FFFF);
        rd_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            do_load(VEC[i][23:12]);
            chk("R2 xa decode", {24'd0, xa_sel_n}, {24'd0, low_at(VEC[i][11:9])});
            chk("R3 xb decode", {24'd0, xb_sel_n}, {24'd0, low_at(VEC[i][8:6])});
            chk("R4 ya decode", {24'd0, ya_sel_n}, {24'd0, low_at(VEC[i][5:3])});
            chk("R4 yb decode", {24'd0, yb_sel_n}, {24'd0, low_at(VEC[i][2:0])});
        end

        do_load(12'o0050);
        chk("R11 octal 50", {16'd0, xa_sel_n, xb_sel_n}, {16'd0, 8'hFE, 8'hDF});

        do_load(12'o1234);
        @(negedge clk);
        addr = 12'o6666;
        repeat (2) @(negedge clk);
        chk("R5 addr change without load", sels(), {low_at(3'd4), low_at(3'd3), low_at(3'd2), low_at(3'd1)});

        rd_n = 1'b0;
        #1;
        chk("R7 read phase drives", {28'd0, drvs()}, 32'b0110);
        rd_n = 1'b1;
        wr_n = 1'b0;
        #1;
        chk("R8 write phase drives", {28'd0, drvs()}, 32'b1001);
        chk("R8 selects kept in write", sels(), {low_at(3'd4), low_at(3'd3), low_at(3'd2), low_at(3'd1)});
        rd_n = 1'b0;
        #1;
        chk("R9 clash drives off", {28'd0, drvs()}, 32'hF);
        wr_n = 1'b1;

        do_load(12'o7777);
        chk("R10 load during read ignored", sels(), {low_at(3'd4), low_at(3'd3), low_at(3'd2), low_at(3'd1)});
        rd_n = 1'b1;
        wr_n = 1'b0;
        do_load(12'o0000);
        chk("R10 load during write ignored", sels(), {low_at(3'd4), low_at(3'd3), low_at(3'd2), low_at(3'd1)});

        en = 1'b0;
        #1;
        chk("R6 disabled selects", sels(), 32'hFFFF_FFFF);
        chk("R6 disabled drives", {28'd0, drvs()}, 32'hF);
        wr_n = 1'b1;
        en = 1'b1;
        #1;
        chk("R6 re-enabled selects", sels(), {low_at(3'd4), low_at(3'd3), low_at(3'd2), low_at(3'd1)});

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 selects after second reset", sels(), 32'hFFFF_FFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule